// File: doc/BRIEF.md
# Serial Flash Byte Read Engine

This block is a register-driven master that reads one byte at a time from a serial NOR flash. Software loads a start address one byte at a time, picks a lane mode, and stores the read opcode for the fast modes. It then writes a trigger code to the command register. The engine lowers chip select and clocks out the opcode and address. It inserts dummy clocks when the mode needs them, shifts in one data byte over one, two or four lanes, and raises chip select again.

While a transfer runs, the command register reads back a non-zero busy code. When that code returns to zero, the byte is available in the data register. The stored address has already moved on by one, so repeating the trigger returns the next flash byte without reloading anything. A second trigger code reads the flash status register through the same pins.

The flash clock is the system clock divided by an even ratio, in SPI mode 0. The transmitted address width, dummy count and divider are parameters.

Top module: `sflash_byte_reader`

## Requirements
- R1: After reset, chip select is high, the flash clock is low, and every register reads 0.
- R2: Writing 0x81 to offset 0x00 while idle starts a byte read. Offset 0x00 reads 0x01 from the next cycle until the transfer ends, then reads 0x00. The received byte is then at offset 0x0C.
- R3: Mode 0x00 (plain) sends opcode 0x03 MSB first on IO0, then the low ADDR_BITS address bits on IO0, with no dummy clocks. Eight data bits are sampled from IO1: 40 flash clocks with the default parameters.
- R4: Mode 0x10 (fast single) sends the opcode held at offset 0x2C and inserts DUMMY_CLKS dummy clocks before 8 single-lane data clocks.
- R5: Mode 0x01 (dual output) uses the opcode at 0x2C and DUMMY_CLKS dummy clocks. Data arrives 2 bits per clock on IO1 (higher bit) and IO0, in 4 clocks.
- R6: Mode 0x03 (dual output with dual address) also sends the address 2 bits per clock on IO1 (higher bit) and IO0, taking ADDR_BITS/2 clocks.
- R7: Mode 0x04 (quad output) uses the opcode at offset 0x30 and DUMMY_CLKS dummy clocks. Data arrives on IO3..IO0 in 2 clocks. IO2 and IO3 are released during the quad dummy and data clocks and are otherwise driven high. IO0 and IO1 are released in every data phase.
- R8: The 32-bit address is written and read back as bytes: bits 7:0 at 0x10, 15:8 at 0x14, 23:16 at 0x18 and 31:24 at 0xC8.
- R9: Each completed byte read adds one to the full 32-bit address, carrying across the byte registers.
- R10: Writing 0x02 to offset 0x00 sends opcode 0x05, reads 8 bits in 16 flash clocks, and places the result at offset 0x08. Offset 0x00 reads 0x02 while this runs, and the address is left unchanged.
- R11: Register and command writes made during a transfer are ignored. Command values other than 0x81 and 0x02 start nothing.
- R12: The flash clock period is CLK_DIV system cycles. IO outputs change only while the flash clock is low, and the clock idles low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock |
| fl_io_o | output | 4 | Flash IO output values |
| fl_io_oe | output | 4 | Flash IO output enables |
| fl_io_i | input | 4 | Flash IO input values |

## Verification
The busy code is due in the first cycle after the command write edge. A transfer then lasts about CLK_DIV times the number of flash clocks, plus one half period before the first clock edge and one after chip select rises. The bench therefore does not count cycles to the result. It polls offset 0x00 until it reads zero and only then reads the data, status and address registers. The flash model counts rising clock edges per chip-select window, records the opcode and address it saw, and drives data on falling edges, so clock counts and lane ordering are checked at the pins.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam logic [7:0] OFS_CMD  = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h08;
   localparam logic [7:0] OFS_DATA = 8'h0C;
   localparam logic [7:0] OFS_A0   = 8'h10;
   localparam logic [7:0] OFS_A1   = 8'h14;
   localparam logic [7:0] OFS_A2   = 8'h18;
   localparam logic [7:0] OFS_A3   = 8'hC8;
   localparam logic [7:0] OFS_OPA  = 8'h2C;
   localparam logic [7:0] OFS_OPB  = 8'h30;
   localparam logic [7:0] OFS_MODE = 8'hCC;

   localparam logic [7:0] CMD_BYTE = 8'h81;
   localparam logic [7:0] CMD_SR   = 8'h02;
   localparam logic [7:0] OP_PLAIN = 8'h03;
   localparam logic [7:0] OP_SR    = 8'h05;

   localparam int MODE_W = 5;

   typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA} phase_t;

   // dlanes: 0 = one lane, 1 = two lanes, 2 = four lanes
   typedef struct packed {
      logic [7:0] opcode;
      logic       addr2;
      logic [1:0] dlanes;
      logic       dummy;
      logic       sr;
   } xfer_t;
endpackage

// File: rtl/sfr_clkdiv.sv
module sfr_clkdiv #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt <= '0;
            else if (!run)                    cnt <= '0;
            else if (cnt == CW'(HALF - 1))    cnt <= '0;
            else                              cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
   import sfr_pkg::*;
#(
   parameter int ADDR_BITS  = 24,
   parameter int DUMMY_CLKS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  xfer_t                cfg,
   input  logic [ADDR_BITS-1:0] addr,
   input  logic                 tick,
   input  logic [3:0]           io_i,
   output logic                 run,
   output logic                 busy,
   output logic                 done,
   output logic [7:0]           rx,
   output logic                 cs_n,
   output logic                 sck,
   output logic [3:0]           io_o,
   output logic [3:0]           io_oe
);
   localparam int TXW  = 8 + ADDR_BITS;
   localparam int MAXC = (ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS;
   localparam int CW   = $clog2(MAXC + 1);

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} st_t;

   st_t           st;
   phase_t        phase;
   xfer_t         cfg_q;
   logic [TXW-1:0] tx_sr;
   logic [CW-1:0] cnt;
   logic [CW-1:0] data_clks;

   assign data_clks = CW'(4'd8 >> cfg_q.dlanes);
   assign busy      = (st != ST_IDLE);
   assign run       = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         phase <= PH_CMD;
         cfg_q <= '0;
         tx_sr <= '0;
         cnt   <= '0;
         rx    <= '0;
         cs_n  <= 1'b1;
         sck   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               cfg_q <= cfg;
               tx_sr <= {cfg.opcode, addr};
               phase <= PH_CMD;
               cnt   <= CW'(8);
               cs_n  <= 1'b0;
               sck   <= 1'b0;
               st    <= ST_RUN;
            end
            ST_RUN: if (tick) begin
               if (!sck) begin
                  sck <= 1'b1;
                  if (phase == PH_DATA) begin
                     case (cfg_q.dlanes)
                        2'd0:    rx <= {rx[6:0], io_i[1]};
                        2'd1:    rx <= {rx[5:0], io_i[1:0]};
                        default: rx <= {rx[3:0], io_i};
                     endcase
                  end
               end else begin
                  sck <= 1'b0;
                  if (phase == PH_ADDR && cfg_q.addr2) tx_sr <= tx_sr << 2;
                  else                                 tx_sr <= tx_sr << 1;
                  if (cnt == CW'(1)) begin
                     case (phase)
                        PH_CMD: if (cfg_q.sr) begin
                           phase <= PH_DATA;
                           cnt   <= CW'(8);
                        end else begin
                           phase <= PH_ADDR;
                           cnt   <= cfg_q.addr2 ? CW'(ADDR_BITS / 2) : CW'(ADDR_BITS);
                        end
                        PH_ADDR: if (cfg_q.dummy) begin
                           phase <= PH_DUMMY;
                           cnt   <= CW'(DUMMY_CLKS);
                        end else begin
                           phase <= PH_DATA;
                           cnt   <= data_clks;
                        end
                        PH_DUMMY: begin
                           phase <= PH_DATA;
                           cnt   <= data_clks;
                        end
                        default: begin
                           phase <= PH_CMD;
                           cs_n  <= 1'b1;
                           done  <= 1'b1;
                           st    <= ST_GAP;
                        end
                     endcase
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            default: if (tick) st <= ST_IDLE;
         endcase
      end
   end

   logic quad_rel;
   assign quad_rel = (cfg_q.dlanes == 2'd2) && (phase == PH_DUMMY || phase == PH_DATA);

   always_comb begin
      io_o  = {2'b11, 2'b00};
      io_oe = {~quad_rel, ~quad_rel, 2'b00};
      if (!cs_n) begin
         if (phase == PH_CMD) begin
            io_o[0]  = tx_sr[TXW-1];
            io_oe[0] = 1'b1;
         end else if (phase == PH_ADDR) begin
            if (cfg_q.addr2) begin
               io_o[1:0]  = tx_sr[TXW-1 -: 2];
               io_oe[1:0] = 2'b11;
            end else begin
               io_o[0]  = tx_sr[TXW-1];
               io_oe[0] = 1'b1;
            end
         end
      end
   end

   AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);                                                       // R12
   AST_IO_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sck && $past(sck)) |-> $stable(io_o));                      // R12
   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);                                                     // R11
   AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && busy));                                             // R2
endmodule

// File: rtl/sfr_regs.sv
module sfr_regs
   import sfr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [7:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        seq_busy,
   input  logic        seq_done,
   input  logic [7:0]  seq_rx,
   output logic        start,
   output xfer_t       cfg,
   output logic [31:0] addr_q
);
   logic [MODE_W-1:0] mode_q;
   logic [7:0]        opa_q, opb_q, data_q, sr_q;
   logic              kind_sr;
   logic              wr_ok;

   assign wr_ok = reg_we && !seq_busy;
   assign start = wr_ok && (reg_addr == OFS_CMD) &&
                  (reg_wdata == CMD_BYTE || reg_wdata == CMD_SR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         opa_q   <= '0;
         opb_q   <= '0;
         data_q  <= '0;
         sr_q    <= '0;
         addr_q  <= '0;
         kind_sr <= 1'b0;
      end else begin
         if (start) kind_sr <= (reg_wdata == CMD_SR);
         if (seq_done) begin
            if (kind_sr) sr_q <= seq_rx;
            else begin
               data_q <= seq_rx;
               addr_q <= addr_q + 32'd1;
            end
         end
         if (wr_ok) begin
            case (reg_addr)
               OFS_A0:   addr_q[7:0]   <= reg_wdata;
               OFS_A1:   addr_q[15:8]  <= reg_wdata;
               OFS_A2:   addr_q[23:16] <= reg_wdata;
               OFS_A3:   addr_q[31:24] <= reg_wdata;
               OFS_OPA:  opa_q         <= reg_wdata;
               OFS_OPB:  opb_q         <= reg_wdata;
               OFS_MODE: mode_q        <= reg_wdata[MODE_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // lane mode decode: quad wins over dual, dual over fast single
   always_comb begin
      cfg = '0;
      if (reg_wdata == CMD_SR) begin
         cfg.opcode = OP_SR;
         cfg.sr     = 1'b1;
      end else if (mode_q[2]) begin
         cfg.opcode = opb_q;
         cfg.dlanes = 2'd2;
         cfg.dummy  = 1'b1;
      end else if (mode_q[0]) begin
         cfg.opcode = opa_q;
         cfg.dlanes = 2'd1;
         cfg.dummy  = 1'b1;
         cfg.addr2  = mode_q[1];
      end else if (mode_q[4]) begin
         cfg.opcode = opa_q;
         cfg.dummy  = 1'b1;
      end else begin
         cfg.opcode = OP_PLAIN;
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_CMD:  reg_rdata = seq_busy ? (kind_sr ? CMD_SR : 8'h01) : 8'h00;
         OFS_STAT: reg_rdata = sr_q;
         OFS_DATA: reg_rdata = data_q;
         OFS_A0:   reg_rdata = addr_q[7:0];
         OFS_A1:   reg_rdata = addr_q[15:8];
         OFS_A2:   reg_rdata = addr_q[23:16];
         OFS_A3:   reg_rdata = addr_q[31:24];
         OFS_OPA:  reg_rdata = opa_q;
         OFS_OPB:  reg_rdata = opb_q;
         OFS_MODE: reg_rdata = 8'(mode_q);
         default:  reg_rdata = 8'h00;
      endcase
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !kind_sr) |=> (addr_q == $past(addr_q) + 32'd1));        // R9
   AST_SR_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && kind_sr) |=> $stable(addr_q));                           // R10
   AST_BUSY_FREEZES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(seq_busy) && !$past(seq_done)) |-> ($stable(mode_q) && $stable(opa_q)));  // R11
endmodule

// File: rtl/sflash_byte_reader.sv
module sflash_byte_reader
   import sfr_pkg::*;
#(
   parameter int CLK_DIV    = 4,
   parameter int ADDR_BITS  = 24,
   parameter int DUMMY_CLKS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       fl_cs_n,
   output logic       fl_sck,
   output logic [3:0] fl_io_o,
   output logic [3:0] fl_io_oe,
   input  logic [3:0] fl_io_i
);
   localparam int HALF = CLK_DIV / 2;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (ADDR_BITS < 8 || ADDR_BITS > 32 || (ADDR_BITS % 8) != 0) begin : g_bad_addr
         $error("ADDR_BITS must be 8, 16, 24 or 32");
      end
      if (DUMMY_CLKS < 1) begin : g_bad_dummy
         $error("DUMMY_CLKS must be at least 1");
      end
   endgenerate

   logic        start, busy, done, run, tick;
   logic [7:0]  rx;
   xfer_t       cfg;
   logic [31:0] addr_q;

   sfr_regs u_regs (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .seq_busy(busy), .seq_done(done), .seq_rx(rx),
      .start, .cfg, .addr_q
   );

   sfr_clkdiv #(.HALF(HALF)) u_div (
      .clk, .rst_n, .run, .tick
   );

   sfr_seq #(.ADDR_BITS(ADDR_BITS), .DUMMY_CLKS(DUMMY_CLKS)) u_seq (
      .clk, .rst_n, .start, .cfg,
      .addr(addr_q[ADDR_BITS-1:0]),
      .tick, .io_i(fl_io_i), .run, .busy, .done, .rx,
      .cs_n(fl_cs_n), .sck(fl_sck), .io_o(fl_io_o), .io_oe(fl_io_oe)
   );
endmodule

// File: tb/sim_sflash_byte_reader.sv
`timescale 1ns/1ps
module sim_sflash_byte_reader;
   localparam int CLK_DIV = 4;
   localparam logic [7:0] SR_VAL = 8'hC3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       fl_cs_n, fl_sck;
   logic [3:0] fl_io_o, fl_io_oe;
   logic [3:0] fl_io_i = 4'h0;

   always #5 clk = ~clk;

   sflash_byte_reader #(.CLK_DIV(CLK_DIV)) u0 (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .fl_cs_n, .fl_sck, .fl_io_o, .fl_io_oe, .fl_io_i
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction

   function automatic int alen(input logic [7:0] op);
      if (op == 8'h05) return 0;
      if (op == 8'hBB) return 12;
      return 24;
   endfunction
   function automatic int dlen(input logic [7:0] op);
      return (op == 8'h05 || op == 8'h03) ? 0 : 8;
   endfunction
   function automatic int lanes(input logic [7:0] op);
      if (op == 8'h3B || op == 8'hBB) return 2;
      if (op == 8'h6B) return 4;
      return 1;
   endfunction

   // flash model
   int          m_edge, m_last_edges;
   logic [7:0]  m_op;
   logic [23:0] m_addr;
   bit          m_oe_bad, m_wp_bad, m_chg_bad;
   time         m_t0, m_period;

   always @(negedge fl_cs_n or posedge fl_sck) begin
      if (!fl_sck) begin
         m_edge = 0; m_op = 8'h00; m_addr = 24'h0;
         m_oe_bad = 0; m_wp_bad = 0;
      end else if (!fl_cs_n) begin
         if (m_edge == 0) m_t0 = $time;
         if (m_edge == 1) m_period = $time - m_t0;
         if (m_edge < 8) begin
            m_op = {m_op[6:0], fl_io_o[0]};
            if (fl_io_oe[3:2] != 2'b11 || fl_io_o[3:2] != 2'b11) m_wp_bad = 1;
         end else if (m_edge < 8 + alen(m_op)) begin
            if (m_op == 8'hBB) m_addr = {m_addr[21:0], fl_io_o[1], fl_io_o[0]};
            else               m_addr = {m_addr[22:0], fl_io_o[0]};
         end else if (m_edge >= 8 + alen(m_op) + dlen(m_op)) begin
            if (fl_io_oe[1:0] != 2'b00) m_oe_bad = 1;
            if (m_op == 8'h6B && fl_io_oe[3:2] != 2'b00) m_oe_bad = 1;
         end
         m_edge = m_edge + 1;
      end
   end

   always @(posedge fl_cs_n) m_last_edges = m_edge;

   always @(negedge fl_sck) begin
      if (!fl_cs_n && m_edge >= 8) begin
         int st, k, l;
         logic [7:0] b;
         st = 8 + alen(m_op) + dlen(m_op);
         l  = lanes(m_op);
         b  = (m_op == 8'h05) ? SR_VAL : fbyte(m_addr);
         if (m_edge >= st) begin
            k = m_edge - st;
            b = b << (k * l);
            if (l == 1)      fl_io_i = {2'b00, b[7], 1'b0};
            else if (l == 2) fl_io_i = {2'b00, b[7:6]};
            else             fl_io_i = b[7:4];
         end
      end
   end

   always @(fl_io_o) if (!fl_cs_n && fl_sck) m_chg_bad = 1;

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_addr(input logic [31:0] a);
      wr(8'h10, a[7:0]); wr(8'h14, a[15:8]); wr(8'h18, a[23:16]); wr(8'hC8, a[31:24]);
   endtask

   task automatic get_addr(output logic [31:0] a);
      logic [7:0] b0, b1, b2, b3;
      rd(8'h10, b0); rd(8'h14, b1); rd(8'h18, b2); rd(8'hC8, b3);
      a = {b3, b2, b1, b0};
   endtask

   task automatic wait_idle;
      logic [7:0] c;
      for (int i = 0; i < 2000; i++) begin
         rd(8'h00, c);
         if (c == 8'h00) return;
      end
      chk(0, "R2 busy never cleared", c, 0);
   endtask

   // mode, opa, opb, addr[23:0], expected opcode, expected clocks
   localparam logic [63:0] VEC [5] = '{
      {8'h00, 8'h00, 8'h00, 24'h123456, 8'h03, 8'd40},
      {8'h10, 8'h0B, 8'h00, 24'hABCDEF, 8'h0B, 8'd48},
      {8'h01, 8'h3B, 8'h00, 24'h00FF10, 8'h3B, 8'd44},
      {8'h03, 8'hBB, 8'h00, 24'h7E5A01, 8'hBB, 8'd32},
      {8'h04, 8'h00, 8'h6B, 24'h3C0F99, 8'h6B, 8'd42}
   };
   localparam string VREQ [5] = '{"R3", "R4", "R5", "R6", "R7"};

   initial begin
      logic [7:0]  d;
      logic [31:0] a;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(fl_cs_n == 1'b1 && fl_sck == 1'b0, "R1 pins", {fl_cs_n, fl_sck}, 2'b10);
      rst_n = 1'b1;
      begin
         logic [7:0] offs [10] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                    8'hC8, 8'h2C, 8'h30, 8'hCC};
         bit allz = 1;
         for (int i = 0; i < 10; i++) begin
            rd(offs[i], d);
            if (d != 8'h00) allz = 0;
         end
         chk(allz, "R1 registers zero", allz, 1);
      end

      // table walk over lane modes
      for (int v = 0; v < 5; v++) begin
         logic [63:0] e;
         e = VEC[v];
         wr(8'hCC, e[63:56]); wr(8'h2C, e[55:48]); wr(8'h30, e[47:40]);
         set_addr({8'h00, e[39:16]});
         m_chg_bad = 0;
         wr(8'h00, 8'h81);
         rd(8'h00, d);
         chk(d == 8'h01, "R2 busy code", d, 8'h01);
         wait_idle();
         rd(8'h0C, d);
         chk(d == fbyte(e[39:16]), {VREQ[v], " data"}, d, fbyte(e[39:16]));
         chk(m_op == e[15:8], {VREQ[v], " opcode"}, m_op, e[15:8]);
         chk(m_addr == e[39:16], {VREQ[v], " address"}, m_addr, e[39:16]);
         chk(m_last_edges == int'(e[7:0]), {VREQ[v], " clock count"}, m_last_edges, e[7:0]);
         chk(!m_oe_bad, {VREQ[v], " R7 lanes released in data"}, m_oe_bad, 0);
         chk(!m_wp_bad, "R7 IO2/IO3 high outside quad data", m_wp_bad, 0);
         chk(!m_chg_bad, "R12 IO changed while SCK high", m_chg_bad, 0);
      end
      chk(m_period == CLK_DIV * 10, "R12 SCK period", m_period, CLK_DIV * 10);

      // R8 address byte readback
      set_addr(32'hA1B2C3D4);
      get_addr(a);
      chk(a == 32'hA1B2C3D4, "R8 address readback", a, 32'hA1B2C3D4);

      // R9 auto increment with carry, plain mode
      wr(8'hCC, 8'h00);
      set_addr(32'h00FFFFFE);
      for (int i = 0; i < 3; i++) begin
         logic [23:0] ea;
         ea = 24'hFFFFFE + 24'(i);
         wr(8'h00, 8'h81);
         wait_idle();
         rd(8'h0C, d);
         chk(d == fbyte(ea) && m_addr == ea, "R9 consecutive byte", {m_addr, d}, {ea, fbyte(ea)});
      end
      get_addr(a);
      chk(a == 32'h01000001, "R9 carry into 0xC8", a, 32'h01000001);

      // R10 status read
      wr(8'h00, 8'h02);
      rd(8'h00, d);
      chk(d == 8'h02, "R10 status busy code", d, 8'h02);
      wait_idle();
      rd(8'h08, d);
      chk(d == SR_VAL, "R10 status value", d, SR_VAL);
      chk(m_op == 8'h05 && m_last_edges == 16, "R10 opcode and clocks", {m_op, 8'(m_last_edges)}, 16'h0510);
      get_addr(a);
      chk(a == 32'h01000001, "R10 address unchanged", a, 32'h01000001);

      // R11 writes during a transfer are ignored
      set_addr(32'h00000040);
      wr(8'h00, 8'h81);
      wr(8'h10, 8'h77);
      wr(8'hCC, 8'h04);
      wr(8'h00, 8'h02);
      wait_idle();
      get_addr(a);
      chk(a == 32'h00000041, "R11 address write ignored", a, 32'h41);
      rd(8'hCC, d);
      chk(d == 8'h00, "R11 mode write ignored", d, 0);
      rd(8'h08, d);
      chk(d == SR_VAL && m_op == 8'h03, "R11 command ignored while busy", m_op, 8'h03);

      // R11 unknown command
      wr(8'h00, 8'h55);
      begin
         bit stayed = 1;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!fl_cs_n) stayed = 0;
         end
         chk(stayed, "R11 unknown command starts nothing", stayed, 1);
      end
      rd(8'h00, d);
      chk(d == 8'h00, "R11 command reads idle", d, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         chk(0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule